// File: doc/BRIEF.md
# Transfer Job Queue Scheduler

This block sits in front of a single DMA channel and keeps a ring of up to eight pending transfer jobs. A producer offers jobs on a submit port; each accepted job is stored in the next ring slot and receives a 32-bit sequence handle, one higher than the previous one. The scheduler starts the jobs on the channel strictly in submission order, one at a time, and watches the channel's done and enable flags to decide when a job has finished.

A job that runs longer than a programmable number of cycles is aborted. The timeout is then rearmed, and the job is retired once the channel drops its enable flag. Finished slots are handed back to the free pool one per cycle. Any agent can ask at any time whether a handle still refers to a pending job. The answer comes from a comparison window that stays correct when the 32-bit handles wrap around.

Descriptor construction and the data movement itself belong to the channel and are not part of this block.

Top module: `xfer_queue_sched`

## Requirements
- R1: After synchronous reset the free-slot count is 8, no job is running, no handle is reported pending, and the channel is commanded off.
- R2: A submission is accepted in a cycle where `sub_valid` is high and the free count is non-zero. The accepted job takes the handle one above the previous handle (the first is 1), reported on `sub_handle`. It is stored in the ring slot reported on `sub_slot`, and slots are taken in order 0..7 with wrap.
- R3: While the free count is zero, `sub_accept` stays low and the handle counter does not advance.
- R4: In a cycle where the channel is idle, or a job completes, and at least one accepted job has not yet been started, `ch_start` pulses. `ch_slot` then gives the ring slot of the oldest unstarted job, and slots are started in order 0..7 with wrap.
- R5: While a job is running, a high `ch_done` completes it in that cycle. `ch_done_clr` and `cpl_valid` pulse, `cpl_aborted` is low, and the done handle advances by one.
- R6: When a running job has been started `TIMEOUT_CYC` cycles earlier without completing, `ch_abort` pulses for one cycle. The job enters the aborting state and the timeout is rearmed, so a further abort pulse follows every `TIMEOUT_CYC` cycles until the job completes.
- R7: While aborting, a low `ch_en` (or a high `ch_done`) completes the job. `cpl_valid` and `ch_done_clr` pulse with `cpl_aborted` high.
- R8: `qry_pending` is high exactly when (done − q) mod 2^32 > 2^23 and (issued − q) mod 2^32 ≤ 2^23. Here q is `qry_handle`, done is the count of completed jobs and issued is the last handle given out. The output is combinational.
- R9: A completed slot is released back to the free pool one slot per cycle, in order. `free_slots` therefore changes by at most one per cycle, decrementing on an accept and incrementing on a release.
- R10: When the channel is idle, or a job completes, and no accepted job is waiting to start, `ch_off` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_valid | input | 1 | A job is offered for submission |
| sub_accept | output | 1 | The offered job is taken this cycle |
| sub_handle | output | 32 | Handle of the job accepted this cycle |
| sub_slot | output | 3 | Ring slot of the job accepted this cycle |
| ch_start | output | 1 | Start the job in `ch_slot` on the channel |
| ch_slot | output | 3 | Ring slot of the job being started |
| ch_abort | output | 1 | Abort command to the channel |
| ch_done_clr | output | 1 | Write-one clear of the channel done flag |
| ch_off | output | 1 | Turn the channel off |
| ch_done | input | 1 | Channel transfer-done flag |
| ch_en | input | 1 | Channel enable flag |
| cpl_valid | output | 1 | A job completed this cycle |
| cpl_aborted | output | 1 | The completing job had been aborted |
| qry_handle | input | 32 | Handle to test |
| qry_pending | output | 1 | The queried handle is still pending |
| free_slots | output | 4 | Number of free ring slots |

## Verification
Several functions of the block can land in the same cycle. The sharpest case is a completion that coincides with the start of the next queued job, where the started slot must already be the advanced one. The other is a submission that lands in the same cycle as a slot release, where the free count must stay unchanged. Both cases are provoked by holding `ch_done` high while the ring is full and submissions keep arriving, and again by random done, enable and submit patterns. Every cycle, each output is compared with a cycle-level model in the bench, so a wrong slot or a stray change in the free count shows up in the exact cycle it occurs.

// File: rtl/xq_pkg.sv
package xq_pkg;

    localparam int HANDLE_W = 32;

    typedef logic [HANDLE_W-1:0] handle_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ABORT = 2'd2
    } chan_st_e;

    typedef struct packed {
        logic start;
        logic abort;
        logic clr;
        logic off;
    } chan_cmd_t;

    // Wraparound-safe liveness test of handle q against done/issued counters.
    function automatic logic handle_live(input handle_t done_h, input handle_t issue_h,
                                         input handle_t q, input int unsigned win_log2);
        handle_t win;
        win = handle_t'(1) << win_log2;
        return ((done_h - q) > win) && ((issue_h - q) <= win);
    endfunction

endpackage

// File: rtl/xq_ring.sv
module xq_ring
    import xq_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int PW = $clog2(SLOTS),
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [PW-1:0] cur_ptr,
    output logic [PW-1:0] head_ptr,
    output logic [CW-1:0] free_cnt,
    output logic          release_slot
);

    logic [PW-1:0] head_q, serv_q;
    logic [CW-1:0] free_q;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    assign release_slot = (serv_q != cur_ptr);
    assign head_ptr     = head_q;
    assign free_cnt     = free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            serv_q <= '0;
            free_q <= CW'(SLOTS);
        end else begin
            if (accept)       head_q <= step_ptr(head_q);
            if (release_slot) serv_q <= step_ptr(serv_q);
            free_q <= free_q + CW'(release_slot) - CW'(accept);
        end
    end

    // R9: pool never exceeds ring size
    p_free_bound_r9: assert property (@(posedge clk) disable iff (rst)
        free_q <= CW'(SLOTS));

    // R9: free count moves by at most one per cycle
    p_free_step_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (free_q == $past(free_q)) || (free_q == $past(free_q) + 1'b1)
                 || (free_q + 1'b1 == $past(free_q)));

endmodule

// File: rtl/xq_chan_ctrl.sv
module xq_chan_ctrl
    import xq_pkg::*;
#(
    parameter int SLOTS       = 8,
    parameter int TIMEOUT_CYC = 16,
    localparam int PW = $clog2(SLOTS),
    localparam int CW = $clog2(SLOTS + 1),
    localparam int TW = $clog2(TIMEOUT_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          ch_done,
    input  logic          ch_en,
    output chan_cmd_t     cmd,
    output logic [PW-1:0] cur_ptr,
    output logic [PW-1:0] start_slot,
    output logic          cpl_valid,
    output logic          cpl_aborted
);

    localparam logic [TW-1:0] RELOAD = TW'(TIMEOUT_CYC - 1);

    chan_st_e      st_q;
    logic [TW-1:0] timer_q;
    logic [PW-1:0] cur_q;
    logic [CW-1:0] outst_q;

    logic active, done_evt, expire, idle_now;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        active    = (st_q != ST_IDLE);
        done_evt  = (active && ch_done) || ((st_q == ST_ABORT) && !ch_en);
        expire    = active && !done_evt && (timer_q == '0);
        idle_now  = !active || done_evt;
        cmd.start = idle_now && (outst_q != '0);
        cmd.off   = idle_now && (outst_q == '0);
        cmd.abort = expire;
        cmd.clr   = done_evt;
    end

    assign cur_ptr     = cur_q;
    assign start_slot  = done_evt ? step_ptr(cur_q) : cur_q;
    assign cpl_valid   = done_evt;
    assign cpl_aborted = done_evt && (st_q == ST_ABORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            timer_q <= '0;
            cur_q   <= '0;
            outst_q <= '0;
        end else begin
            if (done_evt) cur_q <= step_ptr(cur_q);
            outst_q <= outst_q + CW'(accept) - CW'(cmd.start);
            if (cmd.start) begin
                st_q    <= ST_RUN;
                timer_q <= RELOAD;
            end else if (done_evt) begin
                st_q <= ST_IDLE;
            end else if (expire) begin
                st_q    <= ST_ABORT;
                timer_q <= RELOAD;
            end else if (active) begin
                timer_q <= timer_q - 1'b1;
            end
        end
    end

    // R4: a start leaves the channel running
    p_start_run_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.start |=> st_q == ST_RUN);

    // R6: an abort command enters the aborting state
    p_abort_enter_r6: assert property (@(posedge clk) disable iff (rst)
        cmd.abort |=> st_q == ST_ABORT);

    // R5: a completion with nothing to start leaves the channel idle
    p_clr_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr && !cmd.start) |=> st_q == ST_IDLE);

endmodule

// File: rtl/xq_handle_track.sv
module xq_handle_track
    import xq_pkg::*;
#(
    parameter int unsigned WIN_LOG2 = 23
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  logic    cpl_valid,
    input  handle_t qry_handle,
    output handle_t next_handle,
    output logic    qry_pending
);

    handle_t issue_q, done_q;

    assign next_handle = issue_q + 1'b1;
    assign qry_pending = handle_live(done_q, issue_q, qry_handle, WIN_LOG2);

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_q <= '0;
            done_q  <= '0;
        end else begin
            if (accept)    issue_q <= issue_q + 1'b1;
            if (cpl_valid) done_q  <= done_q + 1'b1;
        end
    end

    // R2: every accept advances the issue handle by one
    p_handle_step_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> issue_q == $past(issue_q) + 1'b1);

    // R5: every completion advances the done handle by one
    p_done_step_r5: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> done_q == $past(done_q) + 1'b1);

endmodule

// File: rtl/xfer_queue_sched.sv
module xfer_queue_sched
    import xq_pkg::*;
#(
    parameter int          SLOTS       = 8,
    parameter int          TIMEOUT_CYC = 16,
    parameter int unsigned WIN_LOG2    = 23,
    localparam int PW = $clog2(SLOTS),
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sub_valid,
    output logic          sub_accept,
    output logic [31:0]   sub_handle,
    output logic [PW-1:0] sub_slot,
    output logic          ch_start,
    output logic [PW-1:0] ch_slot,
    output logic          ch_abort,
    output logic          ch_done_clr,
    output logic          ch_off,
    input  logic          ch_done,
    input  logic          ch_en,
    output logic          cpl_valid,
    output logic          cpl_aborted,
    input  logic [31:0]   qry_handle,
    output logic          qry_pending,
    output logic [CW-1:0] free_slots
);

    chan_cmd_t     cmd;
    logic [PW-1:0] cur_ptr;
    logic          release_slot;

    assign sub_accept  = sub_valid && (free_slots != '0);
    assign ch_start    = cmd.start;
    assign ch_abort    = cmd.abort;
    assign ch_done_clr = cmd.clr;
    assign ch_off      = cmd.off;

    xq_ring #(.SLOTS(SLOTS)) u_ring (
        .clk          (clk),
        .rst          (rst),
        .accept       (sub_accept),
        .cur_ptr      (cur_ptr),
        .head_ptr     (sub_slot),
        .free_cnt     (free_slots),
        .release_slot (release_slot)
    );

    xq_chan_ctrl #(.SLOTS(SLOTS), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .accept      (sub_accept),
        .ch_done     (ch_done),
        .ch_en       (ch_en),
        .cmd         (cmd),
        .cur_ptr     (cur_ptr),
        .start_slot  (ch_slot),
        .cpl_valid   (cpl_valid),
        .cpl_aborted (cpl_aborted)
    );

    xq_handle_track #(.WIN_LOG2(WIN_LOG2)) u_track (
        .clk         (clk),
        .rst         (rst),
        .accept      (sub_accept),
        .cpl_valid   (cpl_valid),
        .qry_handle  (qry_handle),
        .next_handle (sub_handle),
        .qry_pending (qry_pending)
    );

    // R3: an empty pool never accepts unless a slot was released the cycle before
    p_no_accept_empty_r3: assert property (@(posedge clk) disable iff (rst)
        (free_slots == '0 && !release_slot) |=> !sub_accept);

endmodule

// File: tb/xfer_queue_sched_bench.sv
module xfer_queue_sched_bench;

    localparam int TO = 16;
    localparam logic [31:0] WIN = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sub_valid = 1'b0;
    logic        ch_done = 1'b0;
    logic        ch_en = 1'b1;
    logic [31:0] qry_handle = '0;

    logic        sub_accept, ch_start, ch_abort, ch_done_clr, ch_off;
    logic        cpl_valid, cpl_aborted, qry_pending;
    logic [31:0] sub_handle;
    logic [2:0]  sub_slot, ch_slot;
    logic [3:0]  free_slots;

    always #4 clk = ~clk;

    xfer_queue_sched #(.SLOTS(8), .TIMEOUT_CYC(TO), .WIN_LOG2(23)) u_xfer_queue_sched (
        .clk(clk), .rst(rst),
        .sub_valid(sub_valid), .sub_accept(sub_accept), .sub_handle(sub_handle),
        .sub_slot(sub_slot), .ch_start(ch_start), .ch_slot(ch_slot),
        .ch_abort(ch_abort), .ch_done_clr(ch_done_clr), .ch_off(ch_off),
        .ch_done(ch_done), .ch_en(ch_en), .cpl_valid(cpl_valid),
        .cpl_aborted(cpl_aborted), .qry_handle(qry_handle),
        .qry_pending(qry_pending), .free_slots(free_slots)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reference state, built from the requirements
    int          m_free, m_head, m_serv, m_cur, m_outst, m_st, m_timer;
    logic [31:0] m_issue, m_done;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic ref_pending(input logic [31:0] q);
        return ((m_done - q) > WIN) && ((m_issue - q) <= WIN);
    endfunction

    task automatic model_reset();
        m_free = 8; m_head = 0; m_serv = 0; m_cur = 0;
        m_outst = 0; m_st = 0; m_timer = 0;
        m_issue = '0; m_done = '0;
    endtask

    // one clock cycle: drive, compare, advance model
    task automatic step(input logic sv, input logic dn, input logic en, input logic [31:0] qh);
        logic e_acc, act, dev, expi, idle, e_start, e_off, rel;
        int   slot_n;
        @(negedge clk);
        sub_valid = sv; ch_done = dn; ch_en = en; qry_handle = qh;
        #1;
        e_acc   = sv && (m_free != 0);
        act     = (m_st != 0);
        dev     = (act && dn) || (m_st == 2 && !en);
        expi    = act && !dev && (m_timer == 0);
        idle    = !act || dev;
        e_start = idle && (m_outst != 0);
        e_off   = idle && (m_outst == 0);
        rel     = (m_serv != m_cur);
        slot_n  = dev ? (m_cur + 1) % 8 : m_cur;

        chk("R3 accept", 32'(sub_accept), 32'(e_acc));
        if (e_acc) begin
            chk("R2 handle", sub_handle, m_issue + 1);
            chk("R2 slot", 32'(sub_slot), 32'(m_head));
        end
        chk("R4 start", 32'(ch_start), 32'(e_start));
        if (e_start) chk("R4 slot", 32'(ch_slot), 32'(slot_n));
        chk("R6 abort", 32'(ch_abort), 32'(expi));
        chk("R5 done_clr", 32'(ch_done_clr), 32'(dev));
        chk("R5 cpl_valid", 32'(cpl_valid), 32'(dev));
        if (dev) chk("R7 cpl_aborted", 32'(cpl_aborted), 32'(m_st == 2));
        chk("R10 off", 32'(ch_off), 32'(e_off));
        chk("R9 free", 32'(free_slots), 32'(m_free));
        chk("R8 pending", 32'(qry_pending), 32'(ref_pending(qh)));

        // advance model
        if (e_acc) begin m_head = (m_head + 1) % 8; m_issue = m_issue + 1; end
        if (rel) m_serv = (m_serv + 1) % 8;
        m_free  = m_free + (rel ? 1 : 0) - (e_acc ? 1 : 0);
        m_outst = m_outst + (e_acc ? 1 : 0) - (e_start ? 1 : 0);
        if (dev) begin m_cur = (m_cur + 1) % 8; m_done = m_done + 1; end
        if (e_start) begin m_st = 1; m_timer = TO - 1; end
        else if (dev) m_st = 0;
        else if (expi) begin m_st = 2; m_timer = TO - 1; end
        else if (act) m_timer = m_timer - 1;
    endtask

    function automatic logic [31:0] pick_query();
        case ($urandom % 6)
            0: return m_done + ($urandom % 4);
            1: return m_issue + ($urandom % 3);
            2: return m_done - WIN + ($urandom % 3) - 1;
            3: return m_issue - WIN + ($urandom % 3) - 1;
            4: return m_done - ($urandom % 3);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 free", 32'(free_slots), 32'd8);
        chk("R1 pending", 32'(qry_pending), 32'd0);
        chk("R1 off", 32'(ch_off), 32'd1);
        chk("R1 start", 32'(ch_start), 32'd0);

        // single job, done after a few cycles (R4, R5, R9)
        step(1, 0, 1, 32'd1);
        step(0, 0, 1, 32'd1);
        step(0, 0, 1, 32'd1);
        step(0, 1, 1, 32'd1);
        repeat (4) step(0, 0, 1, 32'd1);

        // overfill the ring (R3), then let the job time out twice (R6)
        repeat (10) step(1, 0, 1, m_done + 1);
        repeat (2 * TO + 3) step(0, 0, 1, m_issue);
        // enable drops: aborted completion, next starts same cycle (R7, R4)
        step(0, 0, 0, m_done + 1);
        // completions back to back while resubmitting (R5, R9, R2)
        repeat (30) step(1, 1, 1, m_done + 1);
        repeat (12) step(0, 1, 1, m_issue + 1);

        // constrained random mix
        for (int phase = 0; phase < 4; phase++) begin
            for (int i = 0; i < 700; i++) begin
                logic sv, dn, en;
                sv = ($urandom % 4) < (phase == 1 ? 3 : 1);
                dn = ($urandom % 32) < (phase == 2 ? 1 : 5);
                en = ($urandom % 16) != 0;
                step(sv, dn, en, pick_query());
            end
        end

        // drain
        repeat (30) step(0, 1, 1, pick_query());

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule